// File: doc/BRIEF.md
# Six-Way Aggregated GHASH Engine

This block folds a stream of 128-bit data blocks into a running GHASH state over GF(2^128). The caller loads the starting hash and presents a table of six precomputed hash-key powers. It then starts a message by giving its length in blocks and streams the blocks in over a valid/ready handshake. While six or more blocks of the message remain, the engine gathers six of them. It multiplies the first, XORed with the current hash, by the sixth key power, and each following block by the next lower power. The six unreduced products are summed and reduced once. Blocks left after the last full group are absorbed one at a time, each XORed into the hash and multiplied by the first key power.

Block data, the loaded hash and the read-back hash use the external byte layout: byte j sits at bits [8j+7:8j], and the most significant bit of each byte is its lowest-degree coefficient. The engine reverses the bit order inside every byte on entry and again on exit. Internally, bit i is the coefficient of x^i, and products are reduced modulo x^128 + x^7 + x^2 + x + 1. The key-power port already uses this internal form. A one-cycle pulse marks the end of each message, and the buffer holding the partly collected group is zeroed at that moment.

Top module: `ghash_agg`

## Requirements
- R1: A hash loaded while idle reads back unchanged on `hash_out` in the following cycle. Every byte of `hash_in`, `blk_data` and `hash_out` is bit-reversed between the port and the internal form, where bit i is the coefficient of x^i.
- R2: Starting a message of zero blocks pulses `done` in the next cycle and leaves `hash_out` unchanged.
- R3: While at least 6 blocks remain, each group of six blocks b0..b5 sets the hash to (b0 ^ hash)*P6 ^ b1*P5 ^ b2*P4 ^ b3*P3 ^ b4*P2 ^ b5*P1. Here Pk is the 128-bit slot k-1 of `key_pow` (bits [128k-1:128(k-1)]), and the result is reduced once.
- R4: Each block after the last full group sets hash = (hash ^ b)*P1 with full reduction.
- R5: The grouped path is taken only when at least 6 blocks remain at the start of a group. A message of fewer than 6 blocks uses only the single-block path.
- R6: `blk_ready` is low while idle and high while a message is in progress. A block is consumed only in a cycle where `blk_valid` and `blk_ready` are both high.
- R7: `done` pulses for one cycle, in the cycle after the last block is consumed. `hash_out` shows the final hash in that same cycle, and the group buffer is zero.
- R8: `hash_load` while a message is in progress has no effect on the hash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_load | input | 1 | Load `hash_in` into the state (idle only) |
| hash_in | input | 128 | Hash value to load, external layout |
| hash_out | output | 128 | Current hash, external layout |
| key_pow | input | NW*128 | Key powers, slot k-1 holds P(k), internal form |
| msg_start | input | 1 | Start a message (idle only) |
| msg_blocks | input | CW | Block count of the message |
| blk_valid | input | 1 | Block data valid |
| blk_ready | output | 1 | Engine accepts a block |
| blk_data | input | 128 | Data block, external layout |
| done | output | 1 | One-cycle end-of-message pulse |

## Verification
The bench builds the engine with its defaults: six-way aggregation and a 16-bit count, so the grouped and single-block paths meet in every combination up to three groups plus a tail. With true key powers, every count from 0 to 20 is compared against a purely sequential one-block-at-a-time model. With an arbitrary, inconsistent key table, the grouped and single paths give different answers. That makes it visible exactly where the engine switches from groups to single blocks, at counts 5, 6, 7, 12 and 13.

// File: rtl/ghash_agg.sv
module ghash_agg #(
  parameter int NW = 6,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hash_load,
  input  logic [127:0]    hash_in,
  output logic [127:0]    hash_out,
  input  logic [NW*128-1:0] key_pow,
  input  logic            msg_start,
  input  logic [CW-1:0]   msg_blocks,
  input  logic            blk_valid,
  output logic            blk_ready,
  input  logic [127:0]    blk_data,
  output logic            done
);
  localparam int IW = $clog2(NW);
  localparam logic [254:0] POLY = {126'b0, 1'b1, 128'h87};

  function automatic logic [127:0] brev8(input logic [127:0] v);
    logic [127:0] r;
    for (int j = 0; j < 16; j++)
      for (int k = 0; k < 8; k++)
        r[8*j+k] = v[8*j+7-k];
    return r;
  endfunction

  function automatic logic [254:0] clmul(input logic [127:0] a, input logic [127:0] b);
    logic [254:0] r;
    r = '0;
    for (int i = 0; i < 128; i++)
      if (b[i]) r = r ^ ({127'b0, a} << i);
    return r;
  endfunction

  function automatic logic [127:0] reduce(input logic [254:0] p);
    logic [254:0] t;
    t = p;
    for (int i = 254; i >= 128; i--)
      if (t[i]) t = t ^ (POLY << (i - 128));
    return t[127:0];
  endfunction

  logic [127:0] hash;
  logic [127:0] buf_q [NW-1];
  logic [IW-1:0] idx;
  logic [CW-1:0] rem;
  logic         busy;

  logic [127:0] din, nxt;
  logic [127:0] opa [NW];
  logic [127:0] opb [NW];
  logic [254:0] acc;
  logic         take, grp, upd, bufs_zero;

  assign din       = brev8(blk_data);
  assign blk_ready = busy;
  assign hash_out  = brev8(hash);
  assign take      = blk_valid && blk_ready;
  assign grp       = (idx != '0) || (rem >= CW'(NW));
  assign upd       = take && (!grp || idx == IW'(NW-1));

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      opa[i] = '0;
      opb[i] = '0;
    end
    if (grp) begin
      for (int i = 0; i < NW-1; i++) begin
        opa[i] = buf_q[i];
        opb[i] = key_pow[(NW-1-i)*128 +: 128];
      end
      opa[0]    = opa[0] ^ hash;
      opa[NW-1] = din;
      opb[NW-1] = key_pow[127:0];
    end else begin
      opa[0] = hash ^ din;
      opb[0] = key_pow[127:0];
    end
    acc = '0;
    for (int i = 0; i < NW; i++)
      acc = acc ^ clmul(opa[i], opb[i]);
    nxt = reduce(acc);
  end

  always_comb begin
    bufs_zero = 1'b1;
    for (int i = 0; i < NW-1; i++)
      if (buf_q[i] != '0) bufs_zero = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hash <= '0;
      idx  <= '0;
      rem  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      for (int i = 0; i < NW-1; i++) buf_q[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (msg_start) begin
          if (msg_blocks == '0) done <= 1'b1;
          else begin
            busy <= 1'b1;
            rem  <= msg_blocks;
            idx  <= '0;
          end
        end else if (hash_load) begin
          hash <= brev8(hash_in);
        end
      end else if (take) begin
        rem <= rem - 1'b1;
        if (upd) begin
          hash <= nxt;
          idx  <= '0;
        end else begin
          buf_q[idx] <= din;
          idx        <= idx + 1'b1;
        end
        if (rem == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          for (int i = 0; i < NW-1; i++) buf_q[i] <= '0;
        end
      end
    end
  end

  p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && msg_start && msg_blocks == '0) |=> (done && $stable(hash_out)));

  p_group_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && grp && idx != IW'(NW-1)) |=> $stable(hash_out));

  p_ready_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_ready) |-> done);

  p_buf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !msg_start) |-> bufs_zero);

  p_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !take) |=> $stable(hash_out));
endmodule

// File: tb/ghash_agg_tb.sv
module ghash_agg_tb;
  localparam int NW = 6;
  localparam int CW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic hash_load = 0;
  logic [127:0] hash_in = '0;
  logic [127:0] hash_out;
  logic [NW*128-1:0] key_pow = '0;
  logic msg_start = 0;
  logic [CW-1:0] msg_blocks = '0;
  logic blk_valid = 0;
  logic blk_ready;
  logic [127:0] blk_data = '0;
  logic done;

  always #2 clk = ~clk;

  ghash_agg #(.NW(NW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hash_load(hash_load), .hash_in(hash_in),
    .hash_out(hash_out), .key_pow(key_pow), .msg_start(msg_start),
    .msg_blocks(msg_blocks), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_data(blk_data), .done(done));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [127:0] tbl [1:6];
  logic [127:0] blks [0:31];
  logic [127:0] cur_hash = '0;
  logic [127:0] exp_q [$];
  string req_q [$];

  function automatic logic [127:0] rv(input logic [127:0] v);
    logic [127:0] r;
    for (int j = 0; j < 16; j++)
      for (int k = 0; k < 8; k++) r[8*j+k] = v[8*j+7-k];
    return r;
  endfunction

  function automatic logic [127:0] gmul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] z, v;
    logic c;
    z = '0; v = a;
    for (int i = 0; i < 128; i++) begin
      if (b[i]) z = z ^ v;
      c = v[127];
      v = v << 1;
      if (c) v = v ^ 128'h87;
    end
    return z;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] model(input logic [127:0] h_ext, input int n, input bit seq);
    logic [127:0] h;
    int i;
    h = rv(h_ext);
    i = 0;
    if (!seq)
      while (n - i >= 6) begin
        h = gmul(h ^ rv(blks[i]), tbl[6]) ^ gmul(rv(blks[i+1]), tbl[5]) ^
            gmul(rv(blks[i+2]), tbl[4]) ^ gmul(rv(blks[i+3]), tbl[3]) ^
            gmul(rv(blks[i+4]), tbl[2]) ^ gmul(rv(blks[i+5]), tbl[1]);
        i += 6;
      end
    while (i < n) begin
      h = gmul(h ^ rv(blks[i]), tbl[1]);
      i++;
    end
    return rv(h);
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_table(input bit true_pow);
    tbl[1] = rnd128();
    for (int k = 2; k <= 6; k++) tbl[k] = true_pow ? gmul(tbl[k-1], tbl[1]) : rnd128();
    for (int k = 1; k <= 6; k++) key_pow[(k-1)*128 +: 128] = tbl[k];
  endtask

  task automatic run_msg(input int n, input bit gaps, input bit poke, input bit seq, input string req);
    logic [127:0] e;
    for (int i = 0; i < 32; i++) blks[i] = rnd128();
    e = model(cur_hash, n, seq);
    exp_q.push_back(e);
    req_q.push_back(req);
    cur_hash = e;
    msg_start = 1; msg_blocks = CW'(n);
    @(negedge clk);
    msg_start = 0;
    if (n == 0) check("R2 done after empty message", {127'b0, done}, 128'd1);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        repeat ($urandom % 3) begin
          if (poke) begin hash_load = 1; hash_in = rnd128(); end
          @(negedge clk);
          hash_load = 0;
        end
      end
      blk_valid = 1; blk_data = blks[i];
      while (!blk_ready) @(negedge clk);
      @(negedge clk);
      blk_valid = 0;
      if (i == n - 1) check("R7 done after last block", {127'b0, done}, 128'd1);
    end
    @(negedge clk);
    check("R6 ready low when idle", {127'b0, blk_ready}, 128'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected done actual=1 expected=0");
      end else begin
        logic [127:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, hash_out, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] x;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("reset hash_out", hash_out, '0);
    check("R6 reset ready", {127'b0, blk_ready}, 128'd0);
    check("R7 reset done", {127'b0, done}, 128'd0);

    x = rnd128();
    hash_load = 1; hash_in = x;
    @(negedge clk);
    hash_load = 0;
    check("R1 load readback", hash_out, x);
    cur_hash = x;

    set_table(0);
    run_msg(0, 0, 0, 0, "R2 empty message hash");
    run_msg(5, 0, 0, 0, "R5 five blocks single path");
    run_msg(6, 0, 0, 0, "R3 one group");
    run_msg(7, 1, 0, 0, "R4 group plus tail");
    run_msg(12, 1, 0, 0, "R3 two groups");
    run_msg(13, 0, 0, 0, "R4 two groups plus tail");
    run_msg(8, 1, 1, 0, "R8 load ignored while busy");

    set_table(1);
    x = rnd128();
    hash_load = 1; hash_in = x;
    @(negedge clk);
    hash_load = 0;
    cur_hash = x;
    for (int n = 0; n <= 20; n++) run_msg(n, n[0], 0, 1, "R3 R4 R1 aggregated equals sequential");

    repeat (3) @(negedge clk);
    check("R7 all results seen", 128'(exp_q.size()), 128'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule